// File: doc/BRIEF.md
# Logic and Shift Unit

This unit is the bitwise and shift datapath of a small predicated processor. One operation enters on a cycle when `in_valid` is high. Three bitwise operations (AND, OR, XOR) combine a 32-bit source with a 16-bit immediate. The immediate is widened to 32 bits: a select bit puts it in the upper or the lower half, and a fill bit sets every bit of the other half. Two shift operations move the source left or right by a 5-bit amount. A right shift can be arithmetic. Either shift can pass through the carry flag.

The result and the flag values leave the unit one clock after issue, in registers. Each has its own write enable. The register file and the status register of the surrounding core apply those enables. The predicate outcome and the status-update bit are inputs, and the unit turns them into the enables. The add/subtract path, memory access and instruction decode sit outside this block.

Top module: `lsu_unit`

## Requirements
- R1: The immediate widens to 32 bits. With `in_hi`=0 it occupies bits 15:0, and with `in_hi`=1 it occupies bits 31:16. Every bit of the other half equals `in_fill`. AND, OR and XOR then combine this value with `in_src`.
- R2: XOR with immediate 0xFFFF, `in_hi`=0 and `in_fill`=1 returns the bitwise inverse of `in_src`.
- R3: A bitwise operation never writes the carry flag (`out_cf_we`=0).
- R4: Whenever flags are written, `out_zf` is 1 exactly when the 32-bit result is zero, and `out_sf` equals bit 31 of the result.
- R5: A left shift by n (1..31) moves zeros into the vacated low bits. With `in_thru_c`=1, `in_cf` is placed at bit n-1 and `out_cf` is source bit 32-n, the last bit shifted out.
- R6: A right shift fills the vacated high bits with zeros when `in_arith`=0. When `in_arith`=1 it fills them with source bit 31.
- R7: A right shift by n with `in_thru_c`=1 places `in_cf` at bit 32-n, above which the R6 fill still applies. `out_cf` is source bit n-1.
- R8: A shift with `in_thru_c`=0 does not write the carry flag.
- R9: A shift by 0 returns `in_src` unchanged and does not write the carry flag.
- R10: With `in_su`=0 no flag is written, and the result is still written.
- R11: With `in_pred`=0 neither the result nor any flag is written.
- R12: Outputs appear one cycle after an issue with `in_valid`=1. The op codes are 0 AND, 1 OR, 2 XOR, 3 shift left and 4 shift right. Codes 5..7, and cycles with no issue, produce no writes.
- R13: After reset all write enables and `out_result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 3 | Operation code |
| in_src | input | 32 | Source operand |
| in_imm | input | 16 | Immediate for bitwise ops |
| in_shamt | input | 5 | Shift amount |
| in_hi | input | 1 | Immediate in upper half |
| in_fill | input | 1 | Fill value for the other half |
| in_arith | input | 1 | Arithmetic right shift |
| in_thru_c | input | 1 | Shift through carry |
| in_su | input | 1 | Flag update enable |
| in_cf | input | 1 | Current carry flag |
| in_pred | input | 1 | Predicate passed |
| out_rd_we | output | 1 | Result write enable |
| out_result | output | 32 | Result value |
| out_zf_we | output | 1 | Zero flag write enable |
| out_sf_we | output | 1 | Sign flag write enable |
| out_cf_we | output | 1 | Carry flag write enable |
| out_zf | output | 1 | Zero flag value |
| out_sf | output | 1 | Sign flag value |
| out_cf | output | 1 | Carry flag value |

## Verification
On every cycle the assertions check the gating of the write enables. A failed predicate, a cleared update bit, an idle cycle or a reserved code each suppresses its writes, and carry is written only by a shift through carry with a non-zero amount. They also check that a zero-amount shift returns the source unchanged and that the inversion idiom returns the inverse. Only the directed scenarios can show the bit-level data results: immediate placement and fill, the positions where the carry enters and leaves, and arithmetic sign fill. They also show the zero and sign flag values over chosen operands.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4
  } lsu_op_e;

  typedef struct packed {
    logic rd_we;
    logic zf_we;
    logic sf_we;
    logic cf_we;
    logic zf;
    logic sf;
    logic cf;
  } lsu_ctl_t;
endpackage

// File: rtl/lsu_imm_expand.sv
module lsu_imm_expand #(
  parameter int DW = 32,
  localparam int IW = DW / 2
) (
  input  logic [IW-1:0] imm,
  input  logic          hi,
  input  logic          fill,
  output logic [DW-1:0] wide
);
  always_comb begin
    if (hi) wide = {imm, {IW{fill}}};
    else    wide = {{IW{fill}}, imm};
  end
endmodule

// File: rtl/lsu_barrel.sv
module lsu_barrel #(
  parameter int DW   = 32,
  parameter bit LEFT = 1'b1,
  localparam int SW  = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] amt,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] stg [0:SW];
  assign stg[0] = din;
  for (genvar k = 0; k < SW; k++) begin : g_stage
    if (LEFT) begin : g_l
      assign stg[k+1] = amt[k] ? (stg[k] << (2**k)) : stg[k];
    end else begin : g_r
      assign stg[k+1] = amt[k] ? (stg[k] >> (2**k)) : stg[k];
    end
  end
  assign dout = stg[SW];
endmodule

// File: rtl/lsu_shifter.sv
module lsu_shifter #(
  parameter int DW  = 32,
  localparam int SW = $clog2(DW)
) (
  input  logic [DW-1:0] src,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  input  logic          thru_c,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] LSB1 = DW'(1);
  localparam logic [DW-1:0] MSB1 = LSB1 << (DW - 1);

  logic [SW-1:0] amt_m1;
  logic [DW-1:0] l_data, l_pre, l_pos, r_data, r_pre, r_mask, r_pos;
  logic [DW-1:0] l_res, r_res, r_fill;

  assign amt_m1 = amt - {{(SW-1){1'b0}}, 1'b1};

  lsu_barrel #(.DW(DW), .LEFT(1'b1)) i_l_data (.din(src),  .amt(amt),    .dout(l_data));
  lsu_barrel #(.DW(DW), .LEFT(1'b1)) i_l_pre  (.din(src),  .amt(amt_m1), .dout(l_pre));
  lsu_barrel #(.DW(DW), .LEFT(1'b1)) i_l_pos  (.din(LSB1), .amt(amt_m1), .dout(l_pos));
  lsu_barrel #(.DW(DW), .LEFT(1'b0)) i_r_data (.din(src),  .amt(amt),    .dout(r_data));
  lsu_barrel #(.DW(DW), .LEFT(1'b0)) i_r_pre  (.din(src),  .amt(amt_m1), .dout(r_pre));
  lsu_barrel #(.DW(DW), .LEFT(1'b0)) i_r_mask (.din(ONES), .amt(amt),    .dout(r_mask));
  lsu_barrel #(.DW(DW), .LEFT(1'b0)) i_r_pos  (.din(MSB1), .amt(amt_m1), .dout(r_pos));

  always_comb begin
    l_res  = l_data;
    if (thru_c && cin) l_res = l_data | l_pos;
    r_fill = (arith && src[DW-1]) ? ~r_mask : '0;
    r_res  = r_data | r_fill;
    if (thru_c) r_res = cin ? (r_res | r_pos) : (r_res & ~r_pos);
    if (amt == '0) begin
      res  = src;
      cout = cin;
    end else if (left) begin
      res  = l_res;
      cout = l_pre[DW-1];
    end else begin
      res  = r_res;
      cout = r_pre[0];
    end
  end
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int DW  = 32,
  localparam int IW = DW / 2,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic [DW-1:0] in_src,
  input  logic [IW-1:0] in_imm,
  input  logic [SW-1:0] in_shamt,
  input  logic          in_hi,
  input  logic          in_fill,
  input  logic          in_arith,
  input  logic          in_thru_c,
  input  logic          in_su,
  input  logic          in_cf,
  input  logic          in_pred,
  output logic          out_rd_we,
  output logic [DW-1:0] out_result,
  output logic          out_zf_we,
  output logic          out_sf_we,
  output logic          out_cf_we,
  output logic          out_zf,
  output logic          out_sf,
  output logic          out_cf
);
  logic [DW-1:0] imm_w, sh_res, nxt_res;
  logic          sh_cout, is_logic, is_shift, go;
  lsu_ctl_t      nxt_ctl, ctl_q;

  lsu_imm_expand #(.DW(DW)) i_imm (
    .imm(in_imm), .hi(in_hi), .fill(in_fill), .wide(imm_w)
  );

  lsu_shifter #(.DW(DW)) i_shift (
    .src(in_src), .amt(in_shamt), .left(in_op == OP_SHL), .arith(in_arith),
    .thru_c(in_thru_c), .cin(in_cf), .res(sh_res), .cout(sh_cout)
  );

  always_comb begin
    is_logic = (in_op == OP_AND) || (in_op == OP_OR) || (in_op == OP_XOR);
    is_shift = (in_op == OP_SHL) || (in_op == OP_SHR);
    go       = in_valid && in_pred && (is_logic || is_shift);
    unique case (in_op)
      OP_AND:  nxt_res = in_src & imm_w;
      OP_OR:   nxt_res = in_src | imm_w;
      OP_XOR:  nxt_res = in_src ^ imm_w;
      default: nxt_res = sh_res;
    endcase
    nxt_ctl.rd_we = go;
    nxt_ctl.zf_we = go && in_su;
    nxt_ctl.sf_we = go && in_su;
    nxt_ctl.cf_we = go && in_su && is_shift && in_thru_c && (in_shamt != '0);
    nxt_ctl.zf    = (nxt_res == '0);
    nxt_ctl.sf    = nxt_res[DW-1];
    nxt_ctl.cf    = sh_cout;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      out_result <= '0;
    end else begin
      ctl_q      <= nxt_ctl;
      out_result <= nxt_res;
    end
  end

  assign out_rd_we = ctl_q.rd_we;
  assign out_zf_we = ctl_q.zf_we;
  assign out_sf_we = ctl_q.sf_we;
  assign out_cf_we = ctl_q.cf_we;
  assign out_zf    = ctl_q.zf;
  assign out_sf    = ctl_q.sf;
  assign out_cf    = ctl_q.cf;
endmodule

// File: rtl/lsu_unit_chk.sv
module lsu_unit_chk #(
  parameter int DW  = 32,
  localparam int IW = DW / 2,
  localparam int SW = $clog2(DW)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic [DW-1:0] in_src,
  input logic [IW-1:0] in_imm,
  input logic [SW-1:0] in_shamt,
  input logic          in_hi,
  input logic          in_fill,
  input logic          in_thru_c,
  input logic          in_su,
  input logic          in_pred,
  input logic          out_rd_we,
  input logic [DW-1:0] out_result,
  input logic          out_zf_we,
  input logic          out_sf_we,
  input logic          out_cf_we
);
  logic is_sh;
  assign is_sh = (in_op == 3'd3) || (in_op == 3'd4);

  a_r11_pred_blocks: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_pred) |=> !(out_rd_we || out_zf_we || out_sf_we || out_cf_we));

  a_r10_su_off: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_su) |=> !(out_zf_we || out_sf_we || out_cf_we));

  a_r12_idle: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || in_op > 3'd4) |=> !(out_rd_we || out_zf_we || out_sf_we || out_cf_we));

  a_r3_logic_no_cf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op <= 3'd2) |=> !out_cf_we);

  a_r8_no_thru_no_cf: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_sh && !in_thru_c) |=> !out_cf_we);

  a_r9_zero_amount: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred && is_sh && in_shamt == '0) |=> (out_result == $past(in_src) && !out_cf_we));

  a_r2_invert: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_pred && in_op == 3'd2 && in_imm == '1 && !in_hi && in_fill)
      |=> (out_result == ~$past(in_src)));

  a_r4_flags_together: assert property (@(posedge clk) disable iff (rst)
    out_cf_we |-> (out_zf_we && out_sf_we && out_rd_we));
endmodule

bind lsu_unit lsu_unit_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_src(in_src),
  .in_imm(in_imm), .in_shamt(in_shamt), .in_hi(in_hi), .in_fill(in_fill),
  .in_thru_c(in_thru_c), .in_su(in_su), .in_pred(in_pred),
  .out_rd_we(out_rd_we), .out_result(out_result), .out_zf_we(out_zf_we),
  .out_sf_we(out_sf_we), .out_cf_we(out_cf_we)
);

// File: tb/test_lsu_unit.sv
module test_lsu_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [31:0] in_src = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic        in_hi = 0, in_fill = 0, in_arith = 0, in_thru_c = 0;
  logic        in_su = 1, in_cf = 0, in_pred = 1;
  logic        out_rd_we, out_zf_we, out_sf_we, out_cf_we, out_zf, out_sf, out_cf;
  logic [31:0] out_result;
  int          n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_unit i_lsu_unit (.*);

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Independent model: one bit per step.
  task automatic model(input logic [2:0] op, input logic [31:0] src, input logic [15:0] imm,
                       input int n, input logic hi, f, a, c, cin,
                       output logic [31:0] r, output logic co);
    logic [31:0] w;
    logic sgn;
    w = hi ? {imm, {16{f}}} : {{16{f}}, imm};
    r = src; co = cin; sgn = src[31];
    case (op)
      3'd0: r = src & w;
      3'd1: r = src | w;
      3'd2: r = src ^ w;
      3'd3: for (int i = 0; i < n; i++) begin
              co = r[31];
              r  = {r[30:0], (i == 0 && c) ? cin : 1'b0};
            end
      3'd4: for (int i = 0; i < n; i++) begin
              co = r[0];
              r  = {(i == 0 && c) ? cin : (a & sgn), r[31:1]};
            end
      default: ;
    endcase
  endtask

  task automatic run(string req, logic [2:0] op, logic [31:0] src, logic [15:0] imm, int n,
                     logic hi, f, a, c, su, cin, pred);
    logic [31:0] er;
    logic eco, we;
    @(negedge clk);
    in_valid = 1; in_op = op; in_src = src; in_imm = imm; in_shamt = 5'(n);
    in_hi = hi; in_fill = f; in_arith = a; in_thru_c = c; in_su = su; in_cf = cin; in_pred = pred;
    @(negedge clk);
    in_valid = 0;
    model(op, src, imm, n, hi, f, a, c, cin, er, eco);
    we = pred && (op <= 3'd4);
    chk(req, "rd_we", 32'(out_rd_we), 32'(we));
    chk(req, "zf_we", 32'(out_zf_we), 32'(we && su));
    chk(req, "sf_we", 32'(out_sf_we), 32'(we && su));
    chk(req, "cf_we", 32'(out_cf_we), 32'(we && su && (op >= 3'd3) && c && n != 0));
    if (we) begin
      chk(req, "result", out_result, er);
      if (su) begin
        chk(req, "zf", 32'(out_zf), 32'(er == 0));
        chk(req, "sf", 32'(out_sf), 32'(er[31]));
      end
      if (out_cf_we) chk(req, "cf", 32'(out_cf), 32'(eco));
    end
  endtask

  task automatic t_reset;
    chk("R13", "rd_we", 32'(out_rd_we), 0);
    chk("R13", "flag_we", 32'({out_zf_we, out_sf_we, out_cf_we}), 0);
    chk("R13", "result", out_result, 0);
  endtask

  task automatic t_place;
    run("R1", 3'd0, 32'hDEAD_BEEF, 16'h0FF0, 0, 0, 0, 0, 0, 1, 0, 1);
    run("R1", 3'd0, 32'hDEAD_BEEF, 16'h0FF0, 0, 0, 1, 0, 0, 1, 0, 1);
    run("R1", 3'd1, 32'h1234_5678, 16'hA5A5, 0, 1, 0, 0, 0, 1, 0, 1);
    run("R1", 3'd2, 32'h1234_5678, 16'hA5A5, 0, 1, 1, 0, 0, 1, 0, 1);
    run("R3", 3'd2, 32'h0000_00FF, 16'h00FF, 0, 0, 0, 0, 1, 1, 1, 1);
  endtask

  task automatic t_not;
    run("R2", 3'd2, 32'h0F0F_3C3C, 16'hFFFF, 0, 0, 1, 0, 0, 1, 0, 1);
    run("R4", 3'd2, 32'hFFFF_FFFF, 16'hFFFF, 0, 0, 1, 0, 0, 1, 0, 1);
    run("R4", 3'd1, 32'h0000_0001, 16'h0000, 0, 1, 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_left;
    run("R5", 3'd3, 32'h8000_0001, 0, 1, 0, 0, 0, 0, 1, 1, 1);
    run("R5", 3'd3, 32'h8000_0001, 0, 1, 0, 0, 0, 1, 1, 1, 1);
    run("R5", 3'd3, 32'h1000_0000, 0, 4, 0, 0, 0, 1, 1, 1, 1);
    run("R5", 3'd3, 32'hFFFF_FFFF, 0, 31, 0, 0, 0, 1, 1, 0, 1);
  endtask

  task automatic t_right;
    run("R6", 3'd4, 32'h8000_0010, 0, 4, 0, 0, 0, 0, 1, 0, 1);
    run("R6", 3'd4, 32'h8000_0010, 0, 4, 0, 0, 1, 0, 1, 0, 1);
    run("R6", 3'd4, 32'h7000_0010, 0, 31, 0, 0, 1, 0, 1, 0, 1);
    run("R7", 3'd4, 32'h0000_0008, 0, 4, 0, 0, 0, 1, 1, 1, 1);
    run("R7", 3'd4, 32'h8000_0007, 0, 3, 0, 0, 1, 1, 1, 0, 1);
    run("R7", 3'd4, 32'h0000_0001, 0, 1, 0, 0, 1, 1, 1, 1, 1);
  endtask

  task automatic t_corner;
    run("R8", 3'd3, 32'h8000_0000, 0, 1, 0, 0, 0, 0, 1, 1, 1);
    run("R9", 3'd3, 32'hCAFE_F00D, 0, 0, 0, 0, 0, 1, 1, 1, 1);
    run("R9", 3'd4, 32'h8BAD_0001, 0, 0, 0, 0, 1, 1, 1, 0, 1);
    run("R10", 3'd4, 32'h0000_0003, 0, 1, 0, 0, 0, 1, 0, 0, 1);
    run("R10", 3'd0, 32'hFFFF_0000, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 1);
    run("R11", 3'd3, 32'hFFFF_FFFF, 0, 3, 0, 0, 0, 1, 1, 1, 0);
    run("R11", 3'd2, 32'h1234_0000, 16'h1111, 0, 0, 0, 0, 0, 1, 0, 0);
    run("R12", 3'd5, 32'h1111_1111, 16'h1111, 2, 0, 0, 0, 1, 1, 1, 1);
    run("R12", 3'd7, 32'h2222_2222, 16'h0000, 0, 0, 0, 0, 0, 1, 0, 1);
    @(negedge clk);
    chk("R12", "idle_we", 32'({out_rd_we, out_zf_we, out_sf_we, out_cf_we}), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_place();
    t_not();
    t_left();
    t_right();
    t_corner();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule